// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block raises an active-low interrupt request whenever the levels on a parallel input port move away from a stored reference copy of that port. Both rising and falling edges on any pin raise the request. The request drops by itself when every pin returns to the reference. It also drops when the bus target reports that this port was read or written. Each such clear loads the port value seen in that cycle as the new reference, so the interrupt circuit is re-armed in the same step.

The port pins arrive already synchronised to the system clock. The bus target supplies two one-cycle strobes: one timed to the acknowledge of a read and one to the acknowledge of a write. It also supplies a qualifier that says the current transfer is addressed to this port. Because the target issues the two strobes at different points of the acknowledge bit, reads and writes clear at different times. Transfers to other targets leave the qualifier low, so they never touch the interrupt state. A difference must be present for a programmable number of consecutive clock edges before the request is driven. This models the assertion delay and filters glitches. The output is given both as a level and as a pull-down enable for an open-drain pad.

Top module: `port_change_irq`

## Requirements
- R1: After reset the request is inactive (irq_n = 1). The reference holds all ones, so an all-ones port keeps the request inactive and any pin reading 0 raises it.
- R2: A difference between port_in and the reference asserts the request (irq_n = 0) at the DELAY-th consecutive rising edge that samples it. A single bit moving 0->1 or 1->0 counts, on any bit.
- R3: When every pin matches the reference again, the request deasserts at the first rising edge that samples the match.
- R4: A rising edge that samples rd_ack = 1 with target_hit = 1 deasserts the request at that edge and loads port_in as the new reference.
- R5: A rising edge that samples wr_ack = 1 with target_hit = 1 has the same effect as R4.
- R6: With target_hit = 0, rd_ack and wr_ack have no effect on the request or on the reference.
- R7: A port change sampled at the same edge as a clear is absorbed into the new reference and raises no request.
- R8: A change that follows a clear is reported with the same DELAY as in R2.
- R9: A difference that lasts fewer than DELAY consecutive sampled edges raises no request.
- R10: irq_oe is always the complement of irq_n; irq_oe = 1 means the pad pulls the line low.
- R11: The request stays asserted while at least one pin still differs, even after other pins have returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_in | input | WIDTH | Synchronised port pin levels |
| target_hit | input | 1 | Current transfer is addressed to this port |
| rd_ack | input | 1 | One-cycle strobe at the acknowledge of a read |
| wr_ack | input | 1 | One-cycle strobe at the acknowledge of a write |
| irq_n | output | 1 | Interrupt request, active low |
| irq_oe | output | 1 | Open-drain pull-down enable for the interrupt pad |

## Verification
The hardest case to reach from the ports is a pin change that lands in exactly the cycle a clear is sampled. By R7 that change must disappear into the new reference instead of raising a request. The stimulus sets the new port value and the strobe in the same cycle, then watches the output for several edges. The other hard case is a difference that is shorter than the delay window. The bench produces it by restoring the pin one edge after changing it. Around these cases, a sweep runs over every reference value and every bit in both directions, alternating read and write clears.

// File: rtl/pci_pkg.sv
package pci_pkg;

  // Width of a counter that must hold 0 .. d-1.
  function automatic int cnt_width(input int d);
    if (d <= 2) return 1;
    return $clog2(d);
  endfunction

endpackage

// File: rtl/pci_rst_sync.sv
module pci_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end

endmodule

// File: rtl/pci_snapshot.sv
module pci_snapshot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] port_in,
  output logic [WIDTH-1:0] ref_q
);

  logic [WIDTH-1:0] ref_d;

  always_comb begin
    ref_d = ref_q;
    if (load) ref_d = port_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '1;
    else        ref_q <= ref_d;
  end

  assert_clear_loads_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ref_q == $past(port_in)));

  assert_ref_held_without_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ref_q));

endmodule

// File: rtl/pci_compare.sv
module pci_compare #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] port_in,
  input  logic [WIDTH-1:0] ref_q,
  output logic             mismatch
);

  logic [WIDTH-1:0] bit_diff;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_diff[i] = port_in[i] ^ ref_q[i];
  end

  assign mismatch = |bit_diff;

endmodule

// File: rtl/pci_assert_delay.sv
module pci_assert_delay #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mismatch,
  input  logic clr,
  output logic irq_q
);

  logic irq_d;

  if (DELAY <= 1) begin : g_direct
    always_comb begin
      irq_d = mismatch & ~clr;
    end
  end else begin : g_count
    localparam int CW = pci_pkg::cnt_width(DELAY);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      irq_d = irq_q;
      if (clr || !mismatch) begin
        cnt_d = '0;
        irq_d = 1'b0;
      end else if (cnt_q == LAST) begin
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assert_rise_needs_diff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(mismatch));

  assert_match_drops_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch |=> !irq_q);

  assert_clear_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq_q);

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int WIDTH = 8,
  parameter int DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] port_in,
  input  logic             target_hit,
  input  logic             rd_ack,
  input  logic             wr_ack,
  output logic             irq_n,
  output logic             irq_oe
);

  logic             rst_sync_n;
  logic             clr;
  logic [WIDTH-1:0] ref_q;
  logic             mismatch;
  logic             irq_q;

  pci_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Either acknowledge strobe clears, only for transfers addressed here.
  assign clr = target_hit & (rd_ack | wr_ack);

  pci_snapshot #(.WIDTH(WIDTH)) i_snapshot (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (clr),
    .port_in (port_in),
    .ref_q   (ref_q)
  );

  pci_compare #(.WIDTH(WIDTH)) i_compare (
    .port_in  (port_in),
    .ref_q    (ref_q),
    .mismatch (mismatch)
  );

  pci_assert_delay #(.DELAY(DELAY)) i_delay (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mismatch (mismatch),
    .clr      (clr),
    .irq_q    (irq_q)
  );

  assign irq_oe = irq_q;
  assign irq_n  = ~irq_q;

  assert_foreign_strobe_ignored_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!target_hit && !mismatch) |=> !irq_q);

  assert_lost_change_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (ref_q == $past(port_in)) && !irq_q);

endmodule

// File: tb/test_port_change_irq.sv
module test_port_change_irq;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 8;
  localparam int DELAY      = 2;

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] port_in;
  logic             target_hit;
  logic             rd_ack;
  logic             wr_ack;
  logic             irq_n;
  logic             irq_oe;

  int  checks;
  int  errors;
  bit  done;

  port_change_irq #(.WIDTH(WIDTH), .DELAY(DELAY)) i_port_change_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_in    (port_in),
    .target_hit (target_hit),
    .rd_ack     (rd_ack),
    .wr_ack     (wr_ack),
    .irq_n      (irq_n),
    .irq_oe     (irq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic exp_n, input string req);
    checks++;
    if (irq_n !== exp_n) begin
      errors++;
      $display("FAIL %s irq_n actual %b expected %b", req, irq_n, exp_n);
    end
    checks++;
    if (irq_oe !== ~exp_n) begin
      errors++;
      $display("FAIL R10 irq_oe actual %b expected %b (%s)", irq_oe, ~exp_n, req);
    end
  endtask

  // Clear with the port at value v, through the read or the write strobe.
  task automatic do_clear(input logic [WIDTH-1:0] v, input bit use_wr);
    port_in    = v;
    target_hit = 1'b1;
    rd_ack     = ~use_wr;
    wr_ack     = use_wr;
    tick();
    target_hit = 1'b0;
    rd_ack     = 1'b0;
    wr_ack     = 1'b0;
    check(1'b1, use_wr ? "R5" : "R4");
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    port_in    = '1;
    target_hit = 1'b0;
    rd_ack     = 1'b0;
    wr_ack     = 1'b0;
    #(CLK_PERIOD * 3 + 1);
    check(1'b1, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(1'b1, "R1");
    end

    // R1: reference after reset is all ones.
    port_in = 8'hFE;
    tick(); check(1'b1, "R1");
    tick(); check(1'b0, "R1");

    // R6: foreign strobes leave the request and the reference alone.
    target_hit = 1'b0; rd_ack = 1'b1;
    tick(); check(1'b0, "R6");
    rd_ack = 1'b0; wr_ack = 1'b1;
    tick(); check(1'b0, "R6");
    wr_ack = 1'b0;
    port_in = 8'hFF;
    tick(); check(1'b1, "R6");

    // R4: read clear drops an asserted request and takes the new reference.
    port_in = 8'hF0;
    tick(); tick(); check(1'b0, "R4");
    do_clear(8'hF0, 1'b0);
    tick(); check(1'b1, "R4");

    // R7: change sampled with the clear is absorbed.
    port_in = 8'h0F; target_hit = 1'b1; wr_ack = 1'b1;
    tick(); check(1'b1, "R7");
    target_hit = 1'b0; wr_ack = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick(); check(1'b1, "R7");
    end

    // R8: change after a clear follows the normal delay.
    port_in = 8'h1F;
    tick(); check(1'b1, "R8");
    tick(); check(1'b0, "R8");

    // R3 / R11: two bits differ, one returns, request holds; both return, drops.
    do_clear(8'h00, 1'b1);
    port_in = 8'h81;
    tick(); tick(); check(1'b0, "R11");
    port_in = 8'h80;
    tick(); check(1'b0, "R11");
    port_in = 8'h00;
    tick(); check(1'b1, "R3");

    // R9: a one-edge glitch is filtered.
    port_in = 8'h20;
    tick(); check(1'b1, "R9");
    port_in = 8'h00;
    for (int i = 0; i < 3; i++) begin
      tick(); check(1'b1, "R9");
    end

    // R2 / R3 sweep: every reference, every bit, both directions.
    for (int v = 0; v < 256; v++) begin
      for (int b = 0; b < WIDTH; b++) begin
        logic [WIDTH-1:0] refv;
        refv = WIDTH'(v);
        do_clear(refv, b[0]);
        port_in = refv ^ (WIDTH'(1) << b);
        tick(); check(1'b1, refv[b] ? "R2 fall" : "R2 rise");
        tick(); check(1'b0, refv[b] ? "R2 fall" : "R2 rise");
        port_in = refv;
        tick(); check(1'b1, "R3");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule